// File: doc/BRIEF.md
# Critical-Word-First Column Burst Sequencer

This block produces the column address sequence for one burst into an open memory row. Its usual job is to fill a cache line. A start pulse carries the column of the word that is needed. The first beat emits that column. Later beats step through the rest of the aligned line and wrap back to its base, so every word of the line is visited exactly once.

The burst length and the ordering come from a small mode register. Software writes it after reset and before it issues bursts. Three line sizes are available, plus a full-row page length. A linear ordering counts upward without wrapping and stops at the last column of the row. The block drives only addresses and beat flags. Data movement and command timing belong to its neighbours.

Top module: `burst_col_gen`

## Requirements
- R1: One clock after an accepted `start`, `beat_valid` rises and `col_addr` equals the `start_col` sampled with that pulse.
- R2: In wrapping order with burst length L, the address on beat k is (start with its low log2(L) bits cleared) OR ((start + k) mod L). The column bits above log2(L) never change during the burst.
- R3: A mode write (`cfg_we` high) takes `cfg_wdata[1:0]` as the length code: 00 = 8, 01 = 16, 10 = 32, 11 = a full row of 2^COL_W words. A wrapping burst gives exactly L valid beats.
- R4: `cfg_wdata[2]` selects the order: 0 = wrapping, 1 = linear. A linear burst steps by +1 from the start column and emits min(L, 2^COL_W − start) beats, so it ends at the last column of the row at the latest.
- R5: `beat_last` is high on the final valid beat of a burst and on no other beat. `beat_valid` is low on the cycle after it.
- R6: `busy` is high on every beat of a burst. A `start` that arrives while `busy` is high, including on the last beat, has no effect on the running burst and does not begin a new one.
- R7: While reset is applied and after it, `beat_valid`, `beat_last` and `busy` are low. The mode register returns to length 8 in wrapping order, even if a burst was running when reset arrived.
- R8: A burst uses the mode captured with its start pulse. A mode write during a burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | Burst request pulse, sampled while idle |
| start_col | input | COL_W | Column of the critical word |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 3 | Mode value: [2] order, [1:0] length code |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | Current beat carries a valid address |
| beat_last | output | 1 | Current beat is the final one of the burst |
| busy | output | 1 | A burst is in progress |

## Verification
A corrupted wrap mask or step shows up at once. The second beat already differs from start+1 within the line, or the upper column bits move, and the per-beat comparison against the computed order catches it. A wrong remaining-beat count only shows at the burst's end: `beat_last` lands early or late, or the beat count differs. The full-row and row-end linear cases push the counter to its widest value. A bad busy or capture path shows within one beat of a start pulse sent during a burst, as a restarted or stretched sequence.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic {
    ORD_WRAP   = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    LEN_8    = 2'd0,
    LEN_16   = 2'd1,
    LEN_32   = 2'd2,
    LEN_PAGE = 2'd3
  } burst_len_e;

  // Mode word layout: [2] order, [1:0] length code
  typedef struct packed {
    burst_order_e order;
    burst_len_e   len;
  } burst_mode_t;

  localparam int MODE_W = $bits(burst_mode_t);

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_wdata,
  output burst_order_e      order,
  output logic [COL_W:0]    len_words
);

  localparam int CNT_W = COL_W + 1;

  burst_mode_t mode_q;
  burst_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (cfg_we) begin
      mode_d = burst_mode_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{order: ORD_WRAP, len: LEN_8};
    end else if (cfg_we) begin
      mode_q <= mode_d;
    end
  end

  always_comb begin
    unique case (mode_q.len)
      LEN_8:    len_words = CNT_W'(8);
      LEN_16:   len_words = CNT_W'(16);
      LEN_32:   len_words = CNT_W'(32);
      default:  len_words = CNT_W'(1) << COL_W;
    endcase
  end

  assign order = mode_q.order;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  burst_order_e     order,
  input  logic [COL_W:0]   len_words,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             busy
);

  localparam int                CNT_W     = COL_W + 1;
  localparam logic [CNT_W-1:0]  ROW_WORDS = CNT_W'(1) << COL_W;
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [COL_W-1:0]  COL_ONE   = COL_W'(1);

  logic             busy_q,   busy_d;
  logic [COL_W-1:0] addr_q,   addr_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [COL_W-1:0] mask_q,   mask_d;
  burst_order_e     order_q,  order_d;

  logic [CNT_W-1:0] span_to_end;
  logic [COL_W-1:0] addr_inc;
  logic             seq_en;

  assign span_to_end = ROW_WORDS - {1'b0, start_col};
  assign addr_inc    = addr_q + COL_ONE;
  assign seq_en      = busy_q | start;

  always_comb begin
    busy_d   = busy_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    mask_d   = mask_q;
    order_d  = order_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        addr_d  = start_col;
        order_d = order;
        // full-row length truncates to zero here, giving an all-ones mask
        mask_d  = len_words[COL_W-1:0] - COL_ONE;
        if (order == ORD_LINEAR && span_to_end < len_words) begin
          remain_d = span_to_end;
        end else begin
          remain_d = len_words;
        end
      end
    end else if (remain_q == CNT_ONE) begin
      busy_d = 1'b0;
    end else begin
      remain_d = remain_q - CNT_ONE;
      if (order_q == ORD_WRAP) begin
        addr_d = (addr_q & ~mask_q) | (addr_inc & mask_q);
      end else begin
        addr_d = addr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      mask_q   <= '0;
      order_q  <= ORD_WRAP;
    end else if (seq_en) begin
      busy_q   <= busy_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      mask_q   <= mask_d;
      order_q  <= order_d;
    end
  end

  assign col_addr   = addr_q;
  assign beat_valid = busy_q;
  assign beat_last  = busy_q & (remain_q == CNT_ONE);
  assign busy       = busy_q;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_wdata,
  output logic [COL_W-1:0]  col_addr,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              busy
);

  logic           rst_core_n;
  burst_order_e   mode_order;
  logic [COL_W:0] mode_len;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  burst_mode_reg #(.COL_W(COL_W)) u_mode_reg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .order     (mode_order),
    .len_words (mode_len)
  );

  burst_col_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .start_col  (start_col),
    .order      (mode_order),
    .len_words  (mode_len),
    .col_addr   (col_addr),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .busy       (busy)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_addr,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             busy
);

  p_first_is_critical_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> col_addr == $past(start_col));

  // every length is at least 8, so the low three bits step by one in either order
  p_low_bits_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(beat_last))
      |-> (col_addr[2:0] - $past(col_addr[2:0])) == 3'd1);

  p_idle_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_valid && !busy);

  p_burst_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_burst_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat_last) |=> busy && beat_valid);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .start      (start),
  .start_col  (start_col),
  .col_addr   (col_addr),
  .beat_valid (beat_valid),
  .beat_last  (beat_last),
  .busy       (busy)
);

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [8:0] col_addr;
  logic       beat_valid, beat_last, busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [8:0] got [0:1023];
  int n, lastcnt, lastpos, busymis;

  always #2 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .col_addr(col_addr),
    .beat_valid(beat_valid), .beat_last(beat_last), .busy(busy)
  );

  // {cfg[2:0], start[8:0], beats[9:0], last address[8:0]}
  localparam logic [30:0] VEC [0:8] = '{
    {3'd0, 9'h043, 10'd8,   9'h042},
    {3'd1, 9'h043, 10'd16,  9'h042},
    {3'd2, 9'h05F, 10'd32,  9'h05E},
    {3'd3, 9'h1F0, 10'd512, 9'h1EF},
    {3'd4, 9'h043, 10'd8,   9'h04A},
    {3'd5, 9'h1FA, 10'd6,   9'h1FF},
    {3'd7, 9'h100, 10'd256, 9'h1FF},
    {3'd0, 9'h047, 10'd8,   9'h046},
    {3'd6, 9'h000, 10'd32,  9'h01F}
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_addr(input logic [2:0] cfg, input logic [8:0] sc, input int k);
    int len;
    int s;
    len = (cfg[1:0] == 2'd3) ? 512 : (8 << cfg[1:0]);
    s = int'(sc);
    if (!cfg[2]) return 9'((s & ~(len - 1)) | ((s + k) & (len - 1)));
    return 9'(s + k);
  endfunction

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // inj_kind 0: start pulse at column 0x80; 1: mode write of inj_cfg
  task automatic run(input logic [8:0] sc, input int inj_beat, input int inj_kind,
                     input logic [2:0] inj_cfg);
    int guard;
    n = 0; lastcnt = 0; lastpos = -1; busymis = 0; guard = 0;
    @(negedge clk);
    start = 1'b1;
    start_col = sc;
    @(negedge clk);
    start = 1'b0;
    while (beat_valid === 1'b1 && guard < 700) begin
      got[n] = col_addr;
      if (beat_last === 1'b1) begin
        lastcnt++;
        lastpos = n;
      end
      if (busy !== 1'b1) busymis++;
      if (n == inj_beat) begin
        if (inj_kind == 0) begin
          start = 1'b1;
          start_col = 9'h080;
        end else begin
          cfg_we = 1'b1;
          cfg_wdata = inj_cfg;
        end
      end
      n++;
      guard++;
      @(negedge clk);
      start = 1'b0;
      cfg_we = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7: idle while reset is applied
    check("R7 valid in reset", beat_valid === 1'b0, int'(beat_valid), 0);
    check("R7 busy in reset", busy === 1'b0, int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 last after reset", beat_last === 1'b0, int'(beat_last), 0);

    // R7: default mode is 8 beats, wrapping
    run(9'h043, -1, 0, 3'd0);
    check("R7 default beat count", n == 8, n, 8);
    check("R7 default wrap addr", got[5] == 9'h040, int'(got[5]), 'h40);

    for (int v = 0; v < 9; v++) begin
      logic [2:0] cfg;
      logic [8:0] sc;
      int expn;
      int bad;
      cfg  = VEC[v][30:28];
      sc   = VEC[v][27:19];
      expn = int'(VEC[v][18:9]);
      write_cfg(cfg);
      run(sc, -1, 0, 3'd0);
      check("R1 first addr", got[0] == sc, int'(got[0]), int'(sc));
      check(cfg[2] ? "R4 beat count" : "R3 beat count", n == expn, n, expn);
      bad = -1;
      for (int k = 0; k < n && k < 1024; k++)
        if (bad < 0 && got[k] != exp_addr(cfg, sc, k)) bad = k;
      if (bad < 0)
        check(cfg[2] ? "R4 order" : "R2 order", got[n-1] == VEC[v][8:0],
              int'(got[n-1]), int'(VEC[v][8:0]));
      else
        check(cfg[2] ? "R4 order" : "R2 order", 1'b0, int'(got[bad]),
              int'(exp_addr(cfg, sc, bad)));
      check("R5 last flag position", lastcnt == 1 && lastpos == n - 1, lastpos, n - 1);
      check("R6 busy on every beat", busymis == 0, busymis, 0);
    end

    // R6: start during a burst is ignored
    write_cfg(3'd0);
    run(9'h010, 2, 0, 3'd0);
    check("R6 count with mid start", n == 8, n, 8);
    check("R6 addr after mid start", got[3] == 9'h013, int'(got[3]), 'h13);
    run(9'h010, 7, 0, 3'd0);
    @(negedge clk);
    check("R6 start on last beat ignored", busy === 1'b0 && beat_valid === 1'b0,
          int'(busy), 0);

    // R8: mode write during a burst applies to the next one
    run(9'h024, 1, 1, 3'b101);
    check("R8 running burst keeps length", n == 8, n, 8);
    check("R8 running burst keeps wrap", got[7] == 9'h023, int'(got[7]), 'h23);
    run(9'h024, -1, 0, 3'd0);
    check("R8 next burst length", n == 16, n, 16);
    check("R8 next burst linear", got[15] == 9'h033, int'(got[15]), 'h33);

    // R7: reset in mid-burst clears outputs and the mode
    write_cfg(3'b101);
    @(negedge clk);
    start = 1'b1;
    start_col = 9'h050;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 reset mid-burst valid", beat_valid === 1'b0, int'(beat_valid), 0);
    check("R7 reset mid-burst busy", busy === 1'b0, int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(9'h043, -1, 0, 3'd0);
    check("R7 mode default after reset", n == 8, n, 8);
    check("R7 wrap default after reset", got[7] == 9'h042, int'(got[7]), 'h42);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule